// File: doc/BRIEF.md
# MDIO PHY Register Autoscan Controller

This block is a management-bus master for Clause 22 MDIO. It keeps a local shadow copy of all 32 registers of up to four external PHYs. When scanning is switched on, it reads those registers one after another without end and stores each result. Software can then fetch any PHY register from the shadow store without waiting for a slow serial frame.

A 32-bit mask selects the PHY addresses in use. The set bits of the mask, taken from the lowest upwards, are bound to local ports 0, 1, 2 and 3. A host request port issues direct reads and writes to any PHY address. These requests are served only between frames. A scan read that is already on the wire always completes first, and after the host frame the scan picks up where it stopped.

The management clock is the system clock divided by a parameter. The line is driven on the falling MDC edge and sampled on the rising edge.

Top module: `mdio_autoscan`

## Requirements
- R1: Every frame is 64 MDC bits, sent MSB first: 32 ones, start bits 01, opcode (10 = read, 01 = write), 5-bit PHY address, 5-bit register index, turnaround (10 driven on writes), then 16 data bits.
- R2: Each MDC bit lasts 2*DIV clocks, low for the first DIV and high for the last DIV. mdio_o changes only when MDC falls. MDC and mdio_oe are low between frames. On reads, mdio_oe is low for the turnaround and data bits (bits 46..63) and high for bits 0..45. On writes, mdio_oe is high for all 64 bits.
- R3: Bit 1 of mgmt_ctrl enables scanning, and the other bits have no effect. While bit 1 is set, scanning repeats without end. While it is clear, no scan frame starts, but host requests are still served.
- R4: Port k is bound to the PHY address of the (k+1)-th lowest set bit of phy_mask. Set bits beyond the fourth are never addressed.
- R5: Scanning reads registers 0 to 31 of a port, then moves to the next bound port. After the last bound port it returns to port 0. Every scan frame is a read.
- R6: With phy_mask all zero, no scan frame is issued even when scanning is enabled.
- R7: A host request accepted during a scan frame starts only after that frame ends, and it is the next frame on the bus. Scanning then continues with the register that follows the interrupted one.
- R8: A request is accepted on a clock edge where host_req is high and host_busy is low. host_busy is high from that edge until the host frame completes. Write address and data are captured at acceptance.
- R9: host_rdata is 0 after reset. It takes the data of each completed host read and keeps that value through later host writes and scan frames.
- R10: Each shadow entry is 0 after reset. At the end of a scan read, the entry for that port and register takes the whole 16-bit value in one edge. sh_rdata shows the entry selected by sh_port and sh_reg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mgmt_ctrl | input | 8 | Management control; bit 1 enables scanning |
| phy_mask | input | 32 | PHY address enable mask |
| host_req | input | 1 | Host access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_phy | input | 5 | Host target PHY address |
| host_reg | input | 5 | Host target register index |
| host_wdata | input | 16 | Host write data |
| host_busy | output | 1 | Host access in progress |
| host_rdata | output | 16 | Data of the last host read |
| sh_port | input | PORTW | Shadow read port select |
| sh_reg | input | 5 | Shadow read register select |
| sh_rdata | output | 16 | Selected shadow entry |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data in |

## Verification
Scanning is run with a five-bit mask to show that the fifth address is never used and that the four bound addresses come out in bit order. A two-bit mask is then used to expose the wrap back to port 0 after the last bound port, and an all-zero mask shows that the bus stays silent. Host reads and writes are started in the middle of scan frames. This separates correct frame-boundary arbitration and resumption from preemption or restarting at register 0. A write whose data is changed after acceptance tells capture-at-acceptance apart from sampling later. A PHY model returns address-dependent data, so that a swap of ports or registers shows up in the shadow store.

// File: rtl/mdio_autoscan.sv
module mdio_autoscan #(
  parameter int DIV   = 2,
  parameter int NPORT = 4,
  parameter int PORTW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       mgmt_ctrl,
  input  logic [31:0]      phy_mask,
  input  logic             host_req,
  input  logic             host_wr,
  input  logic [4:0]       host_phy,
  input  logic [4:0]       host_reg,
  input  logic [15:0]      host_wdata,
  output logic             host_busy,
  output logic [15:0]      host_rdata,
  input  logic [PORTW-1:0] sh_port,
  input  logic [4:0]       sh_reg,
  output logic [15:0]      sh_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  localparam int PW = ($clog2(2*DIV) < 1) ? 1 : $clog2(2*DIV);
  localparam logic [PW-1:0] PH_MID  = PW'(DIV-1);
  localparam logic [PW-1:0] PH_LAST = PW'(2*DIV-1);
  localparam logic [PORTW:0] NP     = (PORTW+1)'(NPORT);

  logic scan_on, unused_ctrl;
  assign scan_on     = mgmt_ctrl[1];
  assign unused_ctrl = ^{mgmt_ctrl[7:2], mgmt_ctrl[0]};

  logic [PORTW:0] nports;
  logic [4:0]     paddr [NPORT];
  always_comb begin
    nports = '0;
    for (int k = 0; k < NPORT; k++) paddr[k] = '0;
    for (int i = 0; i < 32; i++)
      if (phy_mask[i] && nports < NP) begin
        paddr[nports[PORTW-1:0]] = i[4:0];
        nports = nports + (PORTW+1)'(1);
      end
  end

  logic act, mdc_q, fr_rd, fr_host, h_pend, h_wr;
  logic [PW-1:0] ph;
  logic [5:0] bitn;
  logic [63:0] txsh;
  logic [15:0] rxsh, h_wd, rd_q;
  logic [4:0] h_phy, h_reg, fr_reg, sp_reg;
  logic [PORTW-1:0] fr_port, sp_port, psel;
  logic [PORTW:0] nxt_port;
  logic [15:0] shadow [NPORT][32];

  assign psel     = ({1'b0, sp_port} < nports) ? sp_port : '0;
  assign nxt_port = {1'b0, fr_port} + (PORTW+1)'(1);

  logic go_host, go_scan, last;
  assign go_host = !act && h_pend;
  assign go_scan = !act && !h_pend && scan_on && (nports != '0);
  assign last    = act && (ph == PH_LAST) && (bitn == 6'd63);

  function automatic logic [63:0] mk_frame(logic rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : d};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; mdc_q <= 1'b0; fr_rd <= 1'b0; fr_host <= 1'b0;
      h_pend <= 1'b0; h_wr <= 1'b0; h_phy <= '0; h_reg <= '0; h_wd <= '0;
      ph <= '0; bitn <= '0; txsh <= '1; rxsh <= '0; rd_q <= '0;
      fr_reg <= '0; fr_port <= '0; sp_reg <= '0; sp_port <= '0;
    end else begin
      if (host_req && !h_pend) begin
        h_pend <= 1'b1;
        h_wr   <= host_wr;
        h_phy  <= host_phy;
        h_reg  <= host_reg;
        h_wd   <= host_wdata;
      end
      if (go_host) begin
        act <= 1'b1; ph <= '0; bitn <= '0;
        fr_host <= 1'b1; fr_rd <= !h_wr;
        txsh <= mk_frame(!h_wr, h_phy, h_reg, h_wd);
      end else if (go_scan) begin
        act <= 1'b1; ph <= '0; bitn <= '0;
        fr_host <= 1'b0; fr_rd <= 1'b1;
        fr_port <= psel; fr_reg <= sp_reg;
        txsh <= mk_frame(1'b1, paddr[psel], sp_reg, 16'h0000);
      end else if (act) begin
        if (ph == PH_LAST) begin
          ph    <= '0;
          mdc_q <= 1'b0;
          txsh  <= {txsh[62:0], 1'b1};
          if (bitn == 6'd63) begin
            act <= 1'b0;
            if (fr_host) begin
              h_pend <= 1'b0;
              if (fr_rd) rd_q <= rxsh;
            end else if (fr_reg == 5'd31) begin
              sp_reg  <= '0;
              sp_port <= (nxt_port >= nports) ? '0 : nxt_port[PORTW-1:0];
            end else begin
              sp_reg  <= fr_reg + 5'd1;
              sp_port <= fr_port;
            end
          end else begin
            bitn <= bitn + 6'd1;
          end
        end else begin
          ph <= ph + PW'(1);
          if (ph == PH_MID) begin
            mdc_q <= 1'b1;
            if (fr_rd && bitn >= 6'd48) rxsh <= {rxsh[14:0], mdio_i};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORT; p++)
        for (int r = 0; r < 32; r++) shadow[p][r] <= '0;
    end else if (last && !fr_host) begin
      shadow[fr_port][fr_reg] <= rxsh;
    end
  end

  assign mdc        = mdc_q;
  assign mdio_o     = txsh[63];
  assign mdio_oe    = act && (!fr_rd || bitn < 6'd46);
  assign host_busy  = h_pend;
  assign host_rdata = rd_q;
  assign sh_rdata   = shadow[sh_port][sh_reg];
endmodule

// File: rtl/mdio_autoscan_chk.sv
module mdio_autoscan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        act,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        host_busy,
  input logic [15:0] host_rdata,
  input logic [31:0] phy_mask,
  input logic        scan_on
);
  a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !mdc);

  a_r2_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r2_drive_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdc);

  a_r3_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !host_busy && !scan_on) |=> !act);

  a_r6_no_start_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !host_busy && phy_mask == 32'h0) |=> !act);

  a_r8_busy_held_until_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy && !act) |=> host_busy);

  a_r9_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_busy && !$past(host_busy)) |-> $stable(host_rdata));
endmodule

bind mdio_autoscan mdio_autoscan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .act(act), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .host_busy(host_busy), .host_rdata(host_rdata),
  .phy_mask(phy_mask), .scan_on(scan_on)
);

// File: tb/mdio_autoscan_tb_top.sv
module mdio_autoscan_tb_top;
  localparam int DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] mgmt_ctrl = '0;
  logic [31:0] phy_mask = '0;
  logic host_req = 1'b0, host_wr = 1'b0;
  logic [4:0] host_phy = '0, host_reg = '0, sh_reg = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0] sh_port = '0;
  logic host_busy, mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;
  logic [15:0] host_rdata, sh_rdata;

  always #10 clk = ~clk;

  mdio_autoscan #(.DIV(DIV), .NPORT(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .mgmt_ctrl(mgmt_ctrl), .phy_mask(phy_mask),
    .host_req(host_req), .host_wr(host_wr), .host_phy(host_phy), .host_reg(host_reg),
    .host_wdata(host_wdata), .host_busy(host_busy), .host_rdata(host_rdata),
    .sh_port(sh_port), .sh_reg(sh_reg), .sh_rdata(sh_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // PHY model and reference scan state
  logic [15:0] mem  [32][32];
  logic [15:0] sh_m [4][32];
  int e_addr [4];
  int e_n = 0, e_port = 0, e_reg = 0;
  int bi = 0, frames_done = 0;
  logic [63:0] fr = '0, oev = '0;
  bit is_rd = 0;
  logic [15:0] rd_val = '0;
  bit hx_valid = 0, hx_wr = 0;
  int hx_idx = 0;
  logic [4:0] hx_phy, hx_reg;
  logic [15:0] hx_data;

  function automatic void set_mask_model(logic [31:0] m);
    e_n = 0;
    for (int i = 0; i < 32; i++)
      if (m[i] && e_n < 4) begin
        e_addr[e_n] = i;
        e_n++;
      end
  endfunction

  task automatic frame_done();
    logic [1:0] op;
    logic [4:0] pa, ra;
    op = fr[29:28]; pa = fr[27:23]; ra = fr[22:18];
    chk(fr[63:32] == 32'hFFFF_FFFF, "R1", "preamble", fr[63:32], 32'hFFFF_FFFF);
    chk(fr[31:30] == 2'b01, "R1", "start bits", fr[31:30], 1);
    if (op == 2'b10)
      chk(oev == {{46{1'b1}}, {18{1'b0}}}, "R2", "read drive pattern", oev, {{46{1'b1}}, {18{1'b0}}});
    else
      chk(oev == '1, "R2", "write drive pattern", oev, 64'hFFFF_FFFF_FFFF_FFFF);
    if (hx_valid && frames_done == hx_idx) begin
      chk(op == (hx_wr ? 2'b01 : 2'b10), "R7", "host opcode", op, hx_wr ? 1 : 2);
      chk(pa == hx_phy, "R7", "host phy address", pa, hx_phy);
      chk(ra == hx_reg, "R7", "host register", ra, hx_reg);
      if (hx_wr) begin
        chk(fr[17:16] == 2'b10, "R1", "write turnaround", fr[17:16], 2);
        chk(fr[15:0] == hx_data, "R8", "write data captured at accept", fr[15:0], hx_data);
        mem[pa][ra] = fr[15:0];
      end
      hx_valid = 0;
    end else if (e_n == 0) begin
      chk(0, "R6", "unexpected scan frame", pa, 0);
    end else begin
      if (e_port >= e_n) e_port = 0;
      chk(op == 2'b10, "R5", "scan opcode", op, 2);
      chk(pa == e_addr[e_port], "R4", "bound phy address", pa, e_addr[e_port]);
      chk(ra == e_reg, "R5", "scan register order", ra, e_reg);
      sh_m[e_port][e_reg] = mem[pa][ra];
      if (e_reg == 31) begin
        e_reg = 0;
        e_port = (e_port + 1 >= e_n) ? 0 : e_port + 1;
      end else e_reg++;
    end
    frames_done++;
  endtask

  always @(posedge mdc) begin
    fr  = {fr[62:0], mdio_o};
    oev = {oev[62:0], mdio_oe};
    bi++;
    if (bi == 46) begin
      is_rd  = (fr[11:10] == 2'b10);
      rd_val = mem[fr[9:5]][fr[4:0]];
    end
    if (bi == 64) begin
      frame_done();
      bi = 0;
      is_rd = 0;
    end
  end

  always @(negedge mdc)
    mdio_i = (is_rd && bi >= 48 && bi < 64) ? rd_val[63-bi] : 1'b1;

  // per-clock check of MDC high time
  int hi_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc) hi_run++;
      else begin
        if (hi_run != 0) chk(hi_run == DIV, "R2", "mdc high clocks", hi_run, DIV);
        hi_run = 0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d frames expected completion", frames_done);
    finish_run();
  end

  task automatic host_op(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] d, input bit mid);
    logic [15:0] expv, prev;
    if (mid) wait (bi == 20);
    @(negedge clk);
    expv = mem[pa][ra];
    prev = host_rdata;
    hx_wr = wr; hx_phy = pa; hx_reg = ra; hx_data = d;
    hx_idx = mid ? frames_done + 1 : frames_done;
    hx_valid = 1;
    host_req = 1; host_wr = wr; host_phy = pa; host_reg = ra; host_wdata = d;
    @(negedge clk);
    host_req = 0;
    host_wdata = ~d;
    chk(host_busy == 1'b1, "R8", "busy after accept", host_busy, 1);
    wait (host_busy == 1'b0);
    @(negedge clk);
    chk(!hx_valid, "R7", "host frame done before busy clears", hx_valid, 0);
    if (!wr) chk(host_rdata == expv, "R9", "host read data", host_rdata, expv);
    else     chk(host_rdata == prev, "R9", "write leaves read data", host_rdata, prev);
  endtask

  task automatic check_shadow();
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 32; r++) begin
        @(negedge clk);
        sh_port = p[1:0]; sh_reg = r[4:0];
        @(negedge clk);
        chk(sh_rdata == sh_m[p][r], "R10", "shadow entry", sh_rdata, sh_m[p][r]);
      end
  endtask

  initial begin
    int f0;
    logic [15:0] keep;
    for (int a = 0; a < 32; a++)
      for (int r = 0; r < 32; r++) mem[a][r] = {a[4:0], r[4:0], 6'b101101};
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 32; r++) sh_m[p][r] = '0;

    repeat (4) @(negedge clk);
    chk(host_busy == 0, "R8", "busy in reset", host_busy, 0);
    chk(mdc == 0 && mdio_oe == 0, "R2", "bus idle in reset", {mdc, mdio_oe}, 0);
    chk(host_rdata == 0, "R9", "read data reset", host_rdata, 0);
    chk(sh_rdata == 0, "R10", "shadow reset", sh_rdata, 0);
    rst_n = 1;
    @(negedge clk);

    // five set bits: 3,7,12,20,25 -> fifth ignored
    phy_mask = 32'h0210_1088;
    set_mask_model(phy_mask);
    mgmt_ctrl = 8'h02;
    wait (frames_done == 40);
    host_op(1'b0, 5'd9, 5'd4, 16'h0000, 1'b1);
    keep = host_rdata;
    wait (frames_done == 70);
    host_op(1'b1, 5'd3, 5'd2, 16'hBEEF, 1'b1);
    wait (frames_done >= 136);

    mgmt_ctrl = 8'hFD;
    repeat (600) @(negedge clk);
    f0 = frames_done;
    repeat (3000) @(negedge clk);
    chk(frames_done == f0, "R3", "no scan with bit 1 clear", frames_done, f0);
    chk(host_rdata == keep, "R9", "read data held over scans", host_rdata, keep);
    check_shadow();
    chk(sh_m[0][2] == 16'hBEEF, "R10", "rescan sees written value", sh_m[0][2], 16'hBEEF);
    host_op(1'b0, 5'd3, 5'd2, 16'h0000, 1'b0);

    // two set bits: wrap after port 1
    phy_mask = (32'h1 << 5) | (32'h1 << 30);
    set_mask_model(phy_mask);
    mgmt_ctrl = 8'hFF;
    f0 = frames_done;
    wait (frames_done >= f0 + 70);
    mgmt_ctrl = 8'h00;
    repeat (600) @(negedge clk);
    check_shadow();

    // empty mask
    phy_mask = '0;
    set_mask_model(phy_mask);
    mgmt_ctrl = 8'h02;
    f0 = frames_done;
    repeat (3000) @(negedge clk);
    chk(frames_done == f0, "R6", "no frames with empty mask", frames_done, f0);
    chk(mdc == 0, "R6", "mdc idle with empty mask", mdc, 0);
    host_op(1'b0, 5'd17, 5'd9, 16'h0000, 1'b0);
    repeat (50) @(negedge clk);
    finish_run();
  end
endmodule